// File: doc/BRIEF.md
# Byte Register Rotate and Fill Unit

This unit carries out two single-word instructions of a small accumulator-based controller that work on one byte of data memory. The first rotates a memory byte right by one place: the lowest bit wraps around to the top, and no carry is involved. The second fills a memory byte with all ones. A surrounding core hands over a 16-bit instruction word on a start pulse. The unit then walks through four phases, one clock each: it decodes the word, reads the addressed byte, computes the result, and writes the result out. The done strobe rises in the last of these phases.

Each instruction chooses two things. It selects where the rotate result goes: either to the working register (through a write port owned by the core) or back to memory. It also selects how the 12-bit data address is built: from a fixed low/high split of the 8-bit register field, or from a 4-bit bank value supplied by the core. The rotate reports negative and zero flags. The fill reports no flags. Any other instruction word runs through the same four phases and has no effect.

Top module: `bytereg_exec`

## Requirements
- R1: An instruction with bits [15:10] equal to 6'b010000 is a rotate. Its result is the source byte shifted right by one, with source bit 0 placed in result bit 7 (0xD7 gives 0xEB).
- R2: For a rotate, instruction bit 9 selects the destination. With bit 9 = 1 the result is written to memory at the source address and the working register is not written. With bit 9 = 0 the result appears on the working-register write port and memory is not written.
- R3: A rotate raises the flag write enable in its write phase. The negative flag equals result bit 7, and the zero flag is 1 exactly when the result is 0x00.
- R4: An instruction with bits [15:9] equal to 7'b0110100 is a fill. It writes 0xFF to the addressed memory byte, leaves the working register unwritten, and does not raise the flag write enable.
- R5: Instruction bit 8 selects the addressing mode, and bits [7:0] are the register field f. With bit 8 = 1 the address is {bank[3:0], f}. With bit 8 = 0 the bank input is ignored: f below 0x80 maps to 0x000+f, and f of 0x80 or above maps to 0xF00+f.
- R6: A start sampled while idle makes busy rise at that edge. The memory read enable is high in the second busy cycle. Read data is taken in the third. Write enables and done are high only in the fourth, after which busy drops.
- R7: Start and instruction-word changes while busy are ignored. The running instruction completes unchanged, and a start held high is taken again only after one idle cycle, so a new instruction begins every five cycles.
- R8: Any other instruction word issues no memory read, no memory write, no working-register write and no flag write, yet still pulses done in its fourth cycle.
- R9: During and right after reset, busy, done and all read and write enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to execute `instr`; taken only while idle |
| instr | input | 16 | Instruction word |
| bsr | input | 4 | Bank value used when the instruction selects banked addressing |
| mem_addr | output | 12 | Data memory address |
| mem_rd_en | output | 1 | Memory read request; data is expected on the next cycle |
| mem_rd_data | input | 8 | Memory read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_data | output | 8 | Memory write data |
| w_wr_en | output | 1 | Working-register write strobe |
| w_wr_data | output | 8 | Working-register write data |
| stat_wr_en | output | 1 | Flag update strobe |
| n_flag | output | 1 | Negative flag value |
| z_flag | output | 1 | Zero flag value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Write phase of the current instruction |

## Verification
Two events can fall in the same cycle. One is the done strobe of a finishing instruction. The other is a start request aimed at the next one. The bench provokes this by holding start high across a whole instruction, and by swapping the instruction word to a fill while a rotate to the working register is still running. It then judges that the first write targets the working register, that the second instruction's memory write arrives exactly five cycles after the first done, and that exactly two done pulses fall in the ten-cycle window.

// File: rtl/bre_pkg.sv
package bre_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_DEC  = 3'd1,
        PH_RD   = 3'd2,
        PH_PROC = 3'd3,
        PH_WR   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ROR = 2'd1,
        OP_SET = 2'd2
    } op_e;

    localparam logic [5:0] ROR_KEY = 6'b010000;
    localparam logic [6:0] SET_KEY = 7'b0110100;

    typedef struct packed {
        op_e  op;
        logic to_file;
        logic use_bank;
    } dec_t;

endpackage

// File: rtl/bre_decode.sv
module bre_decode
    import bre_pkg::*;
#(
    parameter int DW = 8,
    parameter int IW = 16
) (
    input  logic [IW-1:0] instr,
    output dec_t          ctl,
    output logic [DW-1:0] fsel
);
    localparam int ROR_LSB = IW - 6;
    localparam int SET_LSB = IW - 7;

    always_comb begin
        fsel         = instr[DW-1:0];
        ctl.op       = OP_NOP;
        ctl.to_file  = 1'b0;
        ctl.use_bank = 1'b0;
        if (instr[IW-1:ROR_LSB] == ROR_KEY) begin
            ctl.op       = OP_ROR;
            ctl.to_file  = instr[DW+1];
            ctl.use_bank = instr[DW];
        end else if (instr[IW-1:SET_LSB] == SET_KEY) begin
            ctl.op       = OP_SET;
            ctl.to_file  = 1'b1;
            ctl.use_bank = instr[DW];
        end
    end
endmodule

// File: rtl/bre_addr.sv
module bre_addr #(
    parameter int DW = 8,
    parameter int BW = 4
) (
    input  logic             use_bank,
    input  logic [DW-1:0]    fsel,
    input  logic [BW-1:0]    bank,
    output logic [BW+DW-1:0] addr
);
    // fixed mode: upper half of f selects the top page, lower half page 0
    always_comb begin
        if (use_bank) addr = {bank, fsel};
        else          addr = {{BW{fsel[DW-1]}}, fsel};
    end
endmodule

// File: rtl/bre_alu.sv
module bre_alu
    import bre_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] res,
    output logic          neg,
    output logic          zero
);
    always_comb begin
        unique case (op)
            OP_ROR:  res = {src[0], src[DW-1:1]};
            OP_SET:  res = '1;
            default: res = src;
        endcase
        neg  = res[DW-1];
        zero = (res == '0);
    end
endmodule

// File: rtl/bytereg_exec.sv
module bytereg_exec
    import bre_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 4,
    parameter int IW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [IW-1:0]       instr,
    input  logic [BW-1:0]       bsr,
    output logic [BW+DW-1:0]    mem_addr,
    output logic                mem_rd_en,
    input  logic [DW-1:0]       mem_rd_data,
    output logic                mem_wr_en,
    output logic [DW-1:0]       mem_wr_data,
    output logic                w_wr_en,
    output logic [DW-1:0]       w_wr_data,
    output logic                stat_wr_en,
    output logic                n_flag,
    output logic                z_flag,
    output logic                busy,
    output logic                done
);
    localparam int AW = BW + DW;

    typedef struct packed {
        phase_e        ph;
        logic [IW-1:0] ir;
        op_e           op;
        logic          to_file;
        logic [AW-1:0] addr;
        logic [DW-1:0] res;
        logic          n;
        logic          z;
    } st_t;

    st_t st_d, st_q;

    dec_t          dec_ctl;
    logic [DW-1:0] dec_f;
    logic [AW-1:0] ea;
    logic [DW-1:0] alu_res;
    logic          alu_n, alu_z;

    bre_decode #(.DW(DW), .IW(IW)) u_dec (
        .instr (st_q.ir),
        .ctl   (dec_ctl),
        .fsel  (dec_f)
    );

    bre_addr #(.DW(DW), .BW(BW)) u_addr (
        .use_bank (dec_ctl.use_bank),
        .fsel     (dec_f),
        .bank     (bsr),
        .addr     (ea)
    );

    bre_alu #(.DW(DW)) u_alu (
        .op   (st_q.op),
        .src  (mem_rd_data),
        .res  (alu_res),
        .neg  (alu_n),
        .zero (alu_z)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ir = instr;
                    st_d.ph = PH_DEC;
                end
            end
            PH_DEC: begin
                st_d.op      = dec_ctl.op;
                st_d.to_file = dec_ctl.to_file;
                st_d.addr    = ea;
                st_d.ph      = PH_RD;
            end
            PH_RD: begin
                st_d.ph = PH_PROC;
            end
            PH_PROC: begin
                st_d.res = alu_res;
                st_d.n   = alu_n;
                st_d.z   = alu_z;
                st_d.ph  = PH_WR;
            end
            PH_WR: begin
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy        = (st_q.ph != PH_IDLE);
        done        = (st_q.ph == PH_WR);
        mem_addr    = st_q.addr;
        mem_rd_en   = (st_q.ph == PH_RD) && (st_q.op != OP_NOP);
        mem_wr_en   = done && ((st_q.op == OP_SET) ||
                               (st_q.op == OP_ROR && st_q.to_file));
        w_wr_en     = done && (st_q.op == OP_ROR) && !st_q.to_file;
        stat_wr_en  = done && (st_q.op == OP_ROR);
        mem_wr_data = st_q.res;
        w_wr_data   = st_q.res;
        n_flag      = st_q.n;
        z_flag      = st_q.z;
    end

    // ---------------- assertions ----------------
    logic [DW-1:0] out_data;
    assign out_data = w_wr_en ? w_wr_data : mem_wr_data;

    assert_one_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && w_wr_en));

    assert_flag_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_en |-> (n_flag == out_data[DW-1]));

    assert_flag_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_en |-> (z_flag == (out_data == '0)));

    assert_fill_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !stat_wr_en) |-> (mem_wr_data == '1));

    assert_writes_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en || w_wr_en || stat_wr_en) |-> done);

    assert_read_then_proc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> (busy && !done && !mem_rd_en));

    assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_start_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/bytereg_exec_bench.sv
module bytereg_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] instr;
    logic [3:0]  bsr;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rd_data;
    logic        mem_wr_en;
    logic [7:0]  mem_wr_data;
    logic        w_wr_en;
    logic [7:0]  w_wr_data;
    logic        stat_wr_en;
    logic        n_flag, z_flag, busy, done;

    int total = 0;
    int bad   = 0;
    logic [7:0] src_val;

    always #10 clk = ~clk;

    bytereg_exec u_bytereg_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .bsr(bsr),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
        .w_wr_en(w_wr_en), .w_wr_data(w_wr_data), .stat_wr_en(stat_wr_en),
        .n_flag(n_flag), .z_flag(z_flag), .busy(busy), .done(done)
    );

    // memory response model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= src_val;
    end

    typedef struct packed {
        logic [15:0] ins;
        logic [3:0]  b;
        logic [7:0]  s;
        logic        rd;
        logic [11:0] adr;
        logic        wm;
        logic        ww;
        logic        ws;
        logic [7:0]  dat;
        logic        n;
        logic        z;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{16'h4225, 4'h0, 8'hD7, 1'b1, 12'h025, 1'b1, 1'b0, 1'b1, 8'hEB, 1'b1, 1'b0},
        '{16'h409A, 4'h0, 8'hD7, 1'b1, 12'hF9A, 1'b0, 1'b1, 1'b1, 8'hEB, 1'b1, 1'b0},
        '{16'h4310, 4'h5, 8'h00, 1'b1, 12'h510, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        '{16'h41FF, 4'hC, 8'h01, 1'b1, 12'hCFF, 1'b0, 1'b1, 1'b1, 8'h80, 1'b1, 1'b0},
        '{16'h427F, 4'h0, 8'h02, 1'b1, 12'h07F, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0},
        '{16'h4380, 4'h3, 8'hFF, 1'b1, 12'h380, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0},
        '{16'h4080, 4'h7, 8'h55, 1'b1, 12'hF80, 1'b0, 1'b1, 1'b1, 8'hAA, 1'b1, 1'b0},
        '{16'h6880, 4'h7, 8'h5A, 1'b1, 12'hF80, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
        '{16'h6944, 4'hA, 8'h5A, 1'b1, 12'hA44, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
        '{16'h6800, 4'h9, 8'h00, 1'b1, 12'h000, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0},
        '{16'h0000, 4'h0, 8'h12, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        '{16'h4425, 4'h0, 8'h12, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        '{16'h6A44, 4'h0, 8'h12, 1'b0, 12'h000, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}
    };

    // captured per instruction
    logic        r_rd, r_pre_done, r_done, r_wm, r_ww, r_ws, r_n, r_z, r_busy_after;
    logic [11:0] r_radr, r_wadr;
    logic [7:0]  r_mdat, r_wdat;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] ins, input logic [3:0] b, input logic [7:0] s);
        @(negedge clk);
        instr = ins; bsr = b; src_val = s; start = 1'b1;
        @(negedge clk);               // decode
        start = 1'b0;
        @(negedge clk);               // read
        r_rd = mem_rd_en; r_radr = mem_addr;
        @(negedge clk);               // process
        r_pre_done = done;
        @(negedge clk);               // write
        r_done = done; r_wm = mem_wr_en; r_ww = w_wr_en; r_ws = stat_wr_en;
        r_mdat = mem_wr_data; r_wdat = w_wr_data; r_n = n_flag; r_z = z_flag;
        r_wadr = mem_addr;
        @(negedge clk);
        r_busy_after = busy;
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ndone;
        rst_n = 1'b0; start = 1'b0; instr = '0; bsr = '0; src_val = '0;
        repeat (3) @(negedge clk);
        chk("R9 busy in reset", busy, 0);
        chk("R9 done in reset", done, 0);
        chk("R9 enables in reset", {mem_rd_en, mem_wr_en, w_wr_en, stat_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {busy, done, mem_rd_en, mem_wr_en, w_wr_en, stat_wr_en}, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            run_op(v.ins, v.b, v.s);
            chk(v.rd ? "R6 read enable" : "R8 no read", r_rd, v.rd);
            chk("R6 no early done", r_pre_done, 0);
            chk("R6 done in write phase", r_done, 1);
            chk("R6 idle after done", r_busy_after, 0);
            chk(v.ws ? "R2 memory write" : (v.rd ? "R4 memory write" : "R8 no memory write"), r_wm, v.wm);
            chk(v.rd ? "R2 working write" : "R8 no working write", r_ww, v.ww);
            chk(v.rd ? "R3 flag strobe" : "R8 no flag strobe", r_ws, v.ws);
            if (v.rd) begin
                chk("R5 read address", r_radr, v.adr);
                if (v.wm) begin
                    chk("R5 write address", r_wadr, v.adr);
                    chk(v.ws ? "R1 rotate to memory" : "R4 fill value", r_mdat, v.dat);
                end
                if (v.ww) chk("R1 rotate to working", r_wdat, v.dat);
                if (v.ws) begin
                    chk("R3 negative flag", r_n, v.n);
                    chk("R3 zero flag", r_z, v.z);
                end
            end
        end

        // R7: start held high, instruction word swapped while busy
        @(negedge clk);
        instr = 16'h409A; bsr = 4'h0; src_val = 8'hD7; start = 1'b1;
        ndone = 0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (k == 1) instr = 16'h6880;
            if (done) ndone++;
            if (k == 4) begin
                chk("R7 first op keeps working dest", w_wr_en, 1);
                chk("R7 first op no memory write", mem_wr_en, 0);
                chk("R7 first op data", w_wr_data, 8'hEB);
            end
            if (k == 5) chk("R7 idle gap", busy, 0);
            if (k == 9) begin
                chk("R7 second op fills memory", mem_wr_en, 1);
                chk("R7 second op address", mem_addr, 12'hF80);
            end
            if (k == 10) start = 1'b0;
        end
        chk("R7 two done pulses in window", ndone, 2);
        repeat (6) @(negedge clk);
        chk("R7 quiet after start drops", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule